// File: doc/BRIEF.md
# Bridge Configuration Control Registers

This block holds the type-1 configuration header state of a PCI-to-PCI bridge. The state covers the three bus numbers, the secondary latency timer, the I/O, memory and prefetchable base/limit fields with their upper extensions, the command word and the bridge control word. A configuration agent reaches it through a dword address with four byte enables. Read data returns one cycle after the request.

Neighbouring logic does the address decode. The block tells that logic when to resample the forwarding windows by sending a one-cycle mapping-update strobe. It also sends a one-cycle secondary bus reset pulse when software arms the bus-reset control bit. A separate command loads the disabled-forwarding pattern, which leaves every base above its limit.

A small sequencer FSM drives all output timing. Its states are ST_IDLE, ST_READ_RESP, ST_REMAP and ST_REMAP_SECRST. The FSM moves on every clock edge, and the request accepted at that edge picks the next state:
- A disable command goes to ST_REMAP.
- A write whose byte range touches a window field goes to ST_REMAP.
- Such a write that also raises the bus-reset bit goes to ST_REMAP_SECRST.
- Any other write goes to ST_IDLE.
- A read goes to ST_READ_RESP.
- No request goes to ST_IDLE.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After reset, the following dwords read back as listed:
  - dword 6 (bus numbers and latency) reads 0.
  - dword 15 reads 0. Bridge control is bits 31:16.
  - dword 8 reads 0.
  - dwords 10, 11 and 12 read 0.
  - dword 7 reads 0x00A0_0101.
  - dword 9 reads 0x0001_0001.
  - dword 1 reads 0x00A0_0000.
- R2: A `fwd_disable` pulse changes these dwords, and `map_update` is high in the following cycle:
  - dword 7 bits 7:4 become all ones and bits 15:12 become zero, so it reads 0x00A0_01F1.
  - dwords 8 and 9 get bits 15:4 set and bits 31:20 cleared, so they read 0x0000_FFF0 and 0x0001_FFF1.
  - dwords 10 and 11 become 0.
- R3: A write changes only the bytes whose enable is set, and within them only the writable bits. The writable bits by dword are:
  - dword 1: bits 0x0147.
  - dword 6: all bits.
  - dword 7: bits 0x0000_F0F0.
  - dwords 8 and 9: bits 0xFFF0_FFF0.
  - dwords 10, 11 and 12: all bits.
  - dword 15: bits 0x0FFF_0000.
  - All other dwords: none.
- R4: `cfg_rvalid` is high in exactly the cycle after an accepted read. `cfg_rdata` carries the addressed dword in that cycle.
- R5: `map_update` is high for one cycle, in the cycle after a write whose enabled bytes overlap any of these byte offsets: 0x04–0x05, 0x1C–0x1D, 0x20–0x33 or 0x3E–0x3F.
- R6: A write whose enabled bytes overlap none of the R5 ranges produces no `map_update`. Examples are the bus numbers, the secondary status, the low half of dword 15 and dword 0.
- R7: `sec_bus_reset` is high for one cycle after a write that takes bridge-control bit 6 (dword 15 bit 22) from 0 to 1. It stays low when the bit was already 1 or when the bit is cleared.
- R8: When `SEC_EXPRESS` is 1 and `LEGACY_LAT_WR` is 0, the secondary latency timer (dword 6 bits 31:24) is read-only zero. Otherwise it is writable.
- R9: Status (dword 1 bits 31:16) and secondary status (dword 7 bits 31:16) always read 0x00A0. This value means 66 MHz capable plus fast back-to-back capable. Writes cannot change it.
- R10: Requests in the same cycle are resolved by priority. `fwd_disable` wins over `cfg_wr`, and the write is dropped. `cfg_wr` wins over `cfg_rd`, and the read gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write request |
| cfg_rd | input | 1 | Read request |
| cfg_dw_addr | input | DW_ADDR_W | Dword index into the header |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| fwd_disable | input | 1 | Load the disabled-forwarding pattern |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read response strobe |
| map_update | output | 1 | Forwarding windows must be resampled |
| sec_bus_reset | output | 1 | Secondary bus reset pulse |

## Verification
The bench sweeps every dword with every byte-enable pattern, then compares both the strobe and the readback against a model built from the offset ranges and writable masks.

Each corner case it targets shows up as a specific fault:
- An off-by-one range edge would fire on 0x1E, or stay silent on 0x33 or 0x3E.
- A level-sensitive bus reset would pulse again when the bit is rewritten as 1.
- A swapped disable pattern would leave the base below the limit.
- A wrong priority order would let a write slip past a simultaneous disable.
- A missing parameter check would leave the express latency timer writable.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_RESP,
        ST_REMAP,
        ST_REMAP_SECRST
    } bcr_state_e;

    localparam int unsigned CTRL_DW        = 15;
    localparam int unsigned SECRST_BIT     = 22;

    // Writable bits of each header dword.
    function automatic logic [31:0] bcr_wmask(input int unsigned idx, input logic lat_wr);
        case (idx)
            1:          return 32'h0000_0147;
            6:          return lat_wr ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
            7:          return 32'h0000_F0F0;
            8, 9:       return 32'hFFF0_FFF0;
            10, 11, 12: return 32'hFFFF_FFFF;
            15:         return 32'h0FFF_0000;
            default:    return 32'h0000_0000;
        endcase
    endfunction

    // Constant read-only content merged into read data.
    function automatic logic [31:0] bcr_roval(input int unsigned idx);
        case (idx)
            1:       return 32'h00A0_0000;
            7:       return 32'h00A0_0101;
            9:       return 32'h0001_0001;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Dwords rewritten by the disabled-forwarding command.
    function automatic logic bcr_dis_touch(input int unsigned idx);
        return (idx >= 7) && (idx <= 11);
    endfunction

    function automatic logic [31:0] bcr_disval(input int unsigned idx);
        case (idx)
            7:       return 32'h0000_00F0;
            8, 9:    return 32'h0000_FFF0;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Does a byte-enabled write overlap a forwarding-relevant field?
    function automatic logic bcr_window_hit(input int unsigned idx, input logic [3:0] be);
        case (idx)
            1, 7:              return |be[1:0];
            8, 9, 10, 11, 12:  return |be;
            15:                return |be[3:2];
            default:           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bcr_sequencer.sv
module bcr_sequencer
    import bcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic do_dis,
    input  logic do_wr,
    input  logic do_rd,
    input  logic win_hit,
    input  logic rst_rise,
    output logic map_update,
    output logic sec_bus_reset,
    output logic rd_valid
);

    bcr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (do_dis)
            state_d = ST_REMAP;
        else if (do_wr && win_hit && rst_rise)
            state_d = ST_REMAP_SECRST;
        else if (do_wr && win_hit)
            state_d = ST_REMAP;
        else if (do_rd)
            state_d = ST_READ_RESP;
        else
            state_d = ST_IDLE;
    end

    always_comb begin
        map_update    = 1'b0;
        sec_bus_reset = 1'b0;
        rd_valid      = 1'b0;
        unique case (state_q)
            ST_IDLE:         ;
            ST_READ_RESP:    rd_valid = 1'b1;
            ST_REMAP:        map_update = 1'b1;
            ST_REMAP_SECRST: begin
                map_update    = 1'b1;
                sec_bus_reset = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bcr_regfile.sv
module bcr_regfile
    import bcr_pkg::*;
#(
    parameter int unsigned DW_ADDR_W = 4,
    parameter bit          LAT_WR    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 do_dis,
    input  logic                 do_wr,
    input  logic                 do_rd,
    input  logic [DW_ADDR_W-1:0] addr,
    input  logic [3:0]           be,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic                 win_hit,
    output logic                 rst_rise
);

    localparam int unsigned NUM_DW = 1 << DW_ADDR_W;

    logic [31:0] words [NUM_DW];
    logic [31:0] be_mask;
    logic [31:0] rdata_q;

    assign be_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

    for (genvar g = 0; g < NUM_DW; g++) begin : g_dw
        localparam logic [31:0] WM = bcr_wmask(g, LAT_WR);
        logic [31:0] img_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                img_q <= '0;
            else if (do_dis && bcr_dis_touch(g))
                img_q <= bcr_disval(g);
            else if (do_wr && (addr == DW_ADDR_W'(g)))
                img_q <= (img_q & ~(be_mask & WM)) | (wdata & be_mask & WM);
        end
        assign words[g] = img_q;
    end

    assign win_hit  = bcr_window_hit(int'(addr), be);
    assign rst_rise = (addr == DW_ADDR_W'(CTRL_DW)) && be[2]
                      && wdata[SECRST_BIT] && !words[CTRL_DW][SECRST_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (do_rd) rdata_q <= words[addr] | bcr_roval(int'(addr));
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
    import bcr_pkg::*;
#(
    parameter int unsigned DW_ADDR_W     = 4,
    parameter bit          SEC_EXPRESS   = 1'b0,
    parameter bit          LEGACY_LAT_WR = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [DW_ADDR_W-1:0] cfg_dw_addr,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    input  logic                 fwd_disable,
    output logic [31:0]          cfg_rdata,
    output logic                 cfg_rvalid,
    output logic                 map_update,
    output logic                 sec_bus_reset
);

    localparam bit LAT_WR = !SEC_EXPRESS || LEGACY_LAT_WR;

    logic do_dis, do_wr, do_rd;
    logic win_hit, rst_rise;

    assign do_dis = fwd_disable;
    assign do_wr  = cfg_wr && !fwd_disable;
    assign do_rd  = cfg_rd && !cfg_wr && !fwd_disable;

    bcr_regfile #(
        .DW_ADDR_W (DW_ADDR_W),
        .LAT_WR    (LAT_WR)
    ) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_dis   (do_dis),
        .do_wr    (do_wr),
        .do_rd    (do_rd),
        .addr     (cfg_dw_addr),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .win_hit  (win_hit),
        .rst_rise (rst_rise)
    );

    bcr_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .do_dis        (do_dis),
        .do_wr         (do_wr),
        .do_rd         (do_rd),
        .win_hit       (win_hit),
        .rst_rise      (rst_rise),
        .map_update    (map_update),
        .sec_bus_reset (sec_bus_reset),
        .rd_valid      (cfg_rvalid)
    );

endmodule

// File: rtl/bridge_cfg_regs_chk.sv
module bridge_cfg_regs_chk #(
    parameter int unsigned DW_ADDR_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr,
    input logic                 cfg_rd,
    input logic [DW_ADDR_W-1:0] cfg_dw_addr,
    input logic                 fwd_disable,
    input logic [31:0]          cfg_rdata,
    input logic                 cfg_rvalid,
    input logic                 map_update,
    input logic                 sec_bus_reset
);

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && !cfg_wr && !fwd_disable) |=> cfg_rvalid); // R4

    AST_RVALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_rd && !cfg_wr && !fwd_disable)); // R4

    AST_DISABLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_disable |=> map_update); // R2

    AST_UPDATE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        map_update |-> $past(cfg_wr || fwd_disable)); // R5

    AST_SECRST_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_reset |=> !sec_bus_reset); // R7

    AST_SECRST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_reset |-> $past(cfg_wr && !fwd_disable)); // R7

    AST_WRITE_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr || fwd_disable) |=> !cfg_rvalid); // R10

    AST_STATUS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rvalid && ($past(cfg_dw_addr) == DW_ADDR_W'(1)))
            |-> (cfg_rdata[31:16] == 16'h00A0)); // R9

endmodule

bind bridge_cfg_regs bridge_cfg_regs_chk #(.DW_ADDR_W(DW_ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_rd        (cfg_rd),
    .cfg_dw_addr   (cfg_dw_addr),
    .fwd_disable   (fwd_disable),
    .cfg_rdata     (cfg_rdata),
    .cfg_rvalid    (cfg_rvalid),
    .map_update    (map_update),
    .sec_bus_reset (sec_bus_reset)
);

// File: tb/test_bridge_cfg_regs.sv
module test_bridge_cfg_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0, fwd_disable = 1'b0;
    logic [3:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, rdata_x;
    logic        cfg_rvalid, map_update, sec_bus_reset;
    logic        rvalid_x, mupd_x, srst_x;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model [16];

    always #10 clk = ~clk;

    bridge_cfg_regs i_bridge_cfg_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .fwd_disable(fwd_disable), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .map_update(map_update), .sec_bus_reset(sec_bus_reset));

    bridge_cfg_regs #(.SEC_EXPRESS(1'b1), .LEGACY_LAT_WR(1'b0)) i_bridge_cfg_regs_x (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .fwd_disable(fwd_disable), .cfg_rdata(rdata_x), .cfg_rvalid(rvalid_x),
        .map_update(mupd_x), .sec_bus_reset(srst_x));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_wmask(input int i);
        case (i)
            1: return 32'h0000_0147;
            6: return 32'hFFFF_FFFF;
            7: return 32'h0000_F0F0;
            8, 9: return 32'hFFF0_FFF0;
            10, 11, 12: return 32'hFFFF_FFFF;
            15: return 32'h0FFF_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_ro(input int i);
        case (i)
            1: return 32'h00A0_0000;
            7: return 32'h00A0_0101;
            9: return 32'h0001_0001;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_hit(input int i, input logic [3:0] be);
        for (int k = 0; k < 4; k++) begin
            int b;
            b = 4 * i + k;
            if (be[k] && ((b >= 4 && b <= 5) || (b >= 28 && b <= 29) ||
                          (b >= 32 && b <= 51) || (b >= 62 && b <= 63)))
                return 1'b1;
        end
        return 1'b0;
    endfunction

    // Write; returns strobes seen in the following cycle.
    task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d,
                      output logic mu, output logic sr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw_addr = 4'(a); cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        mu = map_update; sr = sec_bus_reset;
    endtask

    task automatic rd(input int a, output logic [31:0] d, output logic [31:0] dx);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_dw_addr = 4'(a);
        @(negedge clk);
        cfg_rd = 1'b0;
        check("R4 rvalid", {31'b0, cfg_rvalid}, 32'd1);
        d = cfg_rdata; dx = rdata_x;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d, dx, m, wd;
        logic mu, sr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 16; i++) begin
            model[i] = 32'h0;
            rd(i, d, dx);
            check($sformatf("R1 reset dw%0d", i), d, m_ro(i));
        end

        // R3 R5 R6 R9 sweep over every dword and byte-enable pattern
        for (int i = 0; i < 16; i++) begin
            for (int be = 0; be < 16; be++) begin
                logic exp_sr;
                wd = {4{8'(i * 16 + be)}} ^ 32'h5A3C_96E1;
                m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & m_wmask(i);
                exp_sr = (i == 15) && be[2] && wd[22] && !model[15][22];
                wr(i, 4'(be), wd, mu, sr);
                model[i] = (model[i] & ~m) | (wd & m);
                check($sformatf("R5/R6 strobe dw%0d be%h", i, be), {31'b0, mu},
                      {31'b0, m_hit(i, 4'(be))});
                check($sformatf("R7 secrst dw%0d be%h", i, be), {31'b0, sr}, {31'b0, exp_sr});
                rd(i, d, dx);
                check($sformatf("R3 R9 readback dw%0d be%h", i, be), d, model[i] | m_ro(i));
            end
        end

        // R7 edge-only bus reset
        wr(15, 4'hC, 32'h0, mu, sr);  model[15] = 32'h0;
        check("R7 clear no pulse", {31'b0, sr}, 32'd0);
        wr(15, 4'h4, 32'h0040_0000, mu, sr); model[15] = 32'h0040_0000;
        check("R7 rise pulse", {31'b0, sr}, 32'd1);
        check("R5 ctrl strobe", {31'b0, mu}, 32'd1);
        wr(15, 4'h4, 32'h0040_0000, mu, sr);
        check("R7 held no pulse", {31'b0, sr}, 32'd0);
        @(negedge clk);
        check("R7 one wide", {31'b0, sec_bus_reset}, 32'd0);

        // R8 latency timer
        wr(6, 4'hF, 32'hFFFF_FFFF, mu, sr); model[6] = 32'hFFFF_FFFF;
        rd(6, d, dx);
        check("R8 writable default", d, 32'hFFFF_FFFF);
        check("R8 express ro zero", dx, 32'h00FF_FFFF);

        // R2 disable forwarding
        @(negedge clk); fwd_disable = 1'b1;
        @(negedge clk); fwd_disable = 1'b0;
        check("R2 strobe", {31'b0, map_update}, 32'd1);
        rd(7, d, dx);  check("R2 dw7", d, 32'h00A0_01F1);
        rd(8, d, dx);  check("R2 dw8", d, 32'h0000_FFF0);
        rd(9, d, dx);  check("R2 dw9", d, 32'h0001_FFF1);
        rd(10, d, dx); check("R2 dw10", d, 32'h0);
        rd(11, d, dx); check("R2 dw11", d, 32'h0);
        rd(6, d, dx);  check("R2 busnum kept", d, 32'hFFFF_FFFF);

        // R10 priority
        @(negedge clk);
        fwd_disable = 1'b1; cfg_wr = 1'b1; cfg_dw_addr = 4'd8; cfg_be = 4'hF; cfg_wdata = 32'h1230_4560;
        @(negedge clk);
        fwd_disable = 1'b0; cfg_wr = 1'b0;
        rd(8, d, dx); check("R10 write dropped", d, 32'h0000_FFF0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_dw_addr = 4'd0; cfg_be = 4'hF;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0;
        check("R10 read ignored", {31'b0, cfg_rvalid}, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule